// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block holds the 4-bit code field and the interrupt flag of each buffer in a small array of CAN transmit message buffers. It lets software cancel a queued frame safely. The CPU writes codes through a single-buffer write port and clears flags by writing ones. A transmit engine loads one active buffer at a time with a strobe and index. It then ends that transmission with exactly one event: done, arbitration lost or error. A freeze input can also end it.

Software cancels a frame by writing the abort code 4'b1001. A buffer that is not in flight takes the code at once, which deactivates it without a flag. For a buffer in flight the write is blocked and, with the global abort enable set, the request is held as pending. It later resolves in one of two ways. If the frame completes, the flag is set and the code returns to inactive. If arbitration is lost, an error occurs or freeze is asserted, the code becomes 1001 and the flag is set. Software writes 1001 and reads the code back: a readback other than 1001 means the frame was already in flight, and the flag tells whether it has finished.

Top module: `can_tx_abort_ctrl`

## Requirements
- R1: After reset every code is 4'b1000 (inactive), every flag is 0 and irq_o is 0.
- R2: A CPU write to a buffer that is not in flight updates its code on the next cycle. Writing 4'b1001 this way deactivates the buffer and sets no flag.
- R3: A load strobe is accepted only when no buffer is in flight and the indexed buffer holds 4'b1100 (active). A load strobe that arrives while a buffer is in flight, or that names a buffer not holding 4'b1100, has no effect.
- R4: A buffer is in flight from the cycle its load is accepted until the cycle its transmission ends. A CPU write to a buffer in flight is blocked, so its code stays 4'b1100. If the abort enable is set and the written value is 4'b1001, a pending abort is captured, unless the transmission ends in that same cycle.
- R5: A done event on the buffer in flight sets the code to 4'b1000, sets its flag and clears any pending abort.
- R6: Arbitration lost or error on a buffer in flight with a pending abort sets the code to 4'b1001 and sets its flag.
- R7: Freeze while the buffer in flight has a pending abort ends the transmission, sets the code to 4'b1001 and sets its flag. Freeze with no pending abort has no effect.
- R8: With the abort enable clear, no pending abort is captured. Arbitration lost or error then leaves the code at 4'b1100 with no flag.
- R9: Writing 1 to a flag-clear bit clears that flag. When a flag is set and cleared in the same cycle, the set wins.
- R10: irq_o is high exactly when some buffer has both its flag and its interrupt enable bit set.
- R11: With the abort enable set but no abort pending, arbitration lost or error leaves the code at 4'b1100 with no flag, and the buffer can be loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| abort_en_i | input | 1 | Global abort enable |
| cpu_wr_i | input | 1 | CPU code write strobe |
| cpu_addr_i | input | IDX_W | Buffer index of the CPU write |
| cpu_code_i | input | 4 | Code value to write |
| flag_clr_i | input | NUM_MB | Write-1-to-clear flag bits |
| irq_en_i | input | NUM_MB | Per-buffer interrupt enables |
| eng_load_i | input | 1 | Engine load strobe |
| eng_load_idx_i | input | IDX_W | Index of the buffer being loaded |
| eng_done_i | input | 1 | Transmission completed |
| eng_arb_lost_i | input | 1 | Arbitration lost |
| eng_err_i | input | 1 | Error during transmission |
| freeze_i | input | 1 | Module in freeze mode |
| code_o | output | 4*NUM_MB | Code of each buffer, buffer i at bits [4i+3:4i] |
| flag_o | output | NUM_MB | Interrupt flag of each buffer |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong in-flight index or a stale pending bit has no visible effect at first. It only shows when the transmission ends: the wrong buffer gets a flag or a 1001 code, or the right buffer keeps 1100, one cycle after the terminating event. A blocked write that wrongly goes through changes code_o on the very next cycle. The bench compares every code, flag and the interrupt on every clock against a behavioural model, so any such divergence is caught in the cycle it first reaches the ports. Directed sequences drive each ending (done, arbitration loss, error, freeze) with and without a pending abort, and with the enable both on and off.

// File: rtl/can_abort_pkg.sv
package can_abort_pkg;
  typedef logic [3:0] mb_code_t;
  localparam mb_code_t CODE_INACTIVE = 4'b1000;
  localparam mb_code_t CODE_ACTIVE   = 4'b1100;
  localparam mb_code_t CODE_ABORT    = 4'b1001;
endpackage

// File: rtl/can_tx_inflight.sv
module can_tx_inflight #(
  parameter int NUM_MB = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic             load_ok_i,
  input  logic             done_i,
  input  logic             fail_i,
  input  logic             freeze_i,
  input  logic             pend_busy_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o
);
  logic end_now;

  assign accept_o = load_i && !busy_o && load_ok_i;
  assign end_now  = busy_o && (done_i || fail_i || (freeze_i && pend_busy_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      idx_o  <= load_idx_i;
    end else if (end_now) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_mb_cell.sv
module can_mb_cell
  import can_abort_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     abort_en_i,
  input  logic     wr_i,
  input  mb_code_t wr_code_i,
  input  logic     inflight_i,
  input  logic     sel_i,
  input  logic     done_i,
  input  logic     fail_i,
  input  logic     freeze_i,
  input  logic     clr_i,
  output mb_code_t code_o,
  output logic     flag_o,
  output logic     pend_o
);
  mb_code_t code_d;
  logic     pend_d, set_flag;

  always_comb begin
    code_d   = code_o;
    pend_d   = pend_o;
    set_flag = 1'b0;
    if (sel_i && done_i) begin
      code_d   = CODE_INACTIVE;
      pend_d   = 1'b0;
      set_flag = 1'b1;
    end else if (sel_i && pend_o && (fail_i || freeze_i)) begin
      code_d   = CODE_ABORT;
      pend_d   = 1'b0;
      set_flag = 1'b1;
    end else if (wr_i) begin
      if (inflight_i) begin
        // blocked; capture only if transmission continues
        if (abort_en_i && wr_code_i == CODE_ABORT && !(sel_i && fail_i))
          pend_d = 1'b1;
      end else begin
        code_d = wr_code_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= CODE_INACTIVE;
      pend_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      code_o <= code_d;
      pend_o <= pend_d;
      flag_o <= set_flag | (flag_o & ~clr_i);
    end
  end
endmodule

// File: rtl/can_tx_abort_ctrl.sv
module can_tx_abort_ctrl
  import can_abort_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                abort_en_i,
  input  logic                cpu_wr_i,
  input  logic [IDX_W-1:0]    cpu_addr_i,
  input  logic [3:0]          cpu_code_i,
  input  logic [NUM_MB-1:0]   flag_clr_i,
  input  logic [NUM_MB-1:0]   irq_en_i,
  input  logic                eng_load_i,
  input  logic [IDX_W-1:0]    eng_load_idx_i,
  input  logic                eng_done_i,
  input  logic                eng_arb_lost_i,
  input  logic                eng_err_i,
  input  logic                freeze_i,
  output logic [4*NUM_MB-1:0] code_o,
  output logic [NUM_MB-1:0]   flag_o,
  output logic                irq_o
);
  mb_code_t          code_arr [NUM_MB];
  logic [NUM_MB-1:0] pend_vec, flag_vec;
  logic              busy, accept;
  logic [IDX_W-1:0]  busy_idx;
  logic              load_ok, pend_busy, fail;

  assign fail      = eng_arb_lost_i | eng_err_i;
  assign load_ok   = (code_arr[eng_load_idx_i] == CODE_ACTIVE);
  assign pend_busy = pend_vec[busy_idx];

  can_tx_inflight #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_inflight (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (eng_load_i),
    .load_idx_i  (eng_load_idx_i),
    .load_ok_i   (load_ok),
    .done_i      (eng_done_i),
    .fail_i      (fail),
    .freeze_i    (freeze_i),
    .pend_busy_i (pend_busy),
    .busy_o      (busy),
    .idx_o       (busy_idx),
    .accept_o    (accept)
  );

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic sel, load_hit;
    assign sel      = busy && (busy_idx == IDX_W'(i));
    assign load_hit = accept && (eng_load_idx_i == IDX_W'(i));

    can_mb_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .abort_en_i (abort_en_i),
      .wr_i       (cpu_wr_i && (cpu_addr_i == IDX_W'(i))),
      .wr_code_i  (cpu_code_i),
      .inflight_i (sel | load_hit),
      .sel_i      (sel),
      .done_i     (eng_done_i),
      .fail_i     (fail),
      .freeze_i   (freeze_i),
      .clr_i      (flag_clr_i[i]),
      .code_o     (code_arr[i]),
      .flag_o     (flag_vec[i]),
      .pend_o     (pend_vec[i])
    );
    assign code_o[4*i +: 4] = code_arr[i];
  end

  assign flag_o = flag_vec;
  assign irq_o  = |(flag_vec & irq_en_i);
endmodule

// File: rtl/can_tx_abort_chk.sv
module can_tx_abort_chk #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                abort_en_i,
  input logic                cpu_wr_i,
  input logic [IDX_W-1:0]    cpu_addr_i,
  input logic                eng_done_i,
  input logic                eng_arb_lost_i,
  input logic                eng_err_i,
  input logic                freeze_i,
  input logic [4*NUM_MB-1:0] code_o,
  input logic [NUM_MB-1:0]   flag_o,
  input logic                busy_i,
  input logic [IDX_W-1:0]    busy_idx_i,
  input logic [NUM_MB-1:0]   pend_i
);
  logic             any_end;
  logic             blk_q, done_q, abt_q;
  logic [IDX_W-1:0] idx_q;

  assign any_end = eng_done_i | eng_arb_lost_i | eng_err_i | freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= 1'b0;
      done_q <= 1'b0;
      abt_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      blk_q  <= cpu_wr_i && busy_i && (cpu_addr_i == busy_idx_i) && !any_end;
      done_q <= busy_i && eng_done_i;
      abt_q  <= busy_i && !eng_done_i && pend_i[busy_idx_i] &&
                (eng_arb_lost_i || eng_err_i || freeze_i);
      idx_q  <= busy_i ? busy_idx_i : cpu_addr_i;
    end
  end

  AST_PEND_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i != '0) |-> (busy_i && pend_i == (NUM_MB'(1) << busy_idx_i))); // R4

  AST_NO_PEND_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_en_i |=> ((pend_i & ~$past(pend_i)) == '0)); // R8

  AST_FLAG_FROM_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_o & ~$past(flag_o)) != '0) |-> $past(busy_i && any_end)); // R5

  AST_BLOCKED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q |-> (code_o[4*idx_q +: 4] == 4'b1100)); // R4

  AST_DONE_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (code_o[4*idx_q +: 4] == 4'b1000 && flag_o[idx_q])); // R5

  AST_ABORT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abt_q |-> (code_o[4*idx_q +: 4] == 4'b1001 && flag_o[idx_q] && !busy_i)); // R6
endmodule

bind can_tx_abort_ctrl can_tx_abort_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .abort_en_i     (abort_en_i),
  .cpu_wr_i       (cpu_wr_i),
  .cpu_addr_i     (cpu_addr_i),
  .eng_done_i     (eng_done_i),
  .eng_arb_lost_i (eng_arb_lost_i),
  .eng_err_i      (eng_err_i),
  .freeze_i       (freeze_i),
  .code_o         (code_o),
  .flag_o         (flag_o),
  .busy_i         (busy),
  .busy_idx_i     (busy_idx),
  .pend_i         (pend_vec)
);

// File: tb/sim_can_tx_abort_ctrl.sv
`timescale 1ns/1ps
module sim_can_tx_abort_ctrl;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam logic [3:0] C_INA = 4'b1000, C_ACT = 4'b1100, C_ABT = 4'b1001;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic abort_en = 1'b0, cpu_wr = 1'b0, load = 1'b0;
  logic done = 1'b0, arb = 1'b0, err = 1'b0, frz = 1'b0;
  logic [IW-1:0] cpu_addr = '0, load_idx = '0;
  logic [3:0] cpu_code = '0;
  logic [N-1:0] flag_clr = '0, irq_en = '0;
  logic [4*N-1:0] code_o;
  logic [N-1:0] flag_o;
  logic irq_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  can_tx_abort_ctrl #(.NUM_MB(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .abort_en_i(abort_en), .cpu_wr_i(cpu_wr),
    .cpu_addr_i(cpu_addr), .cpu_code_i(cpu_code), .flag_clr_i(flag_clr),
    .irq_en_i(irq_en), .eng_load_i(load), .eng_load_idx_i(load_idx),
    .eng_done_i(done), .eng_arb_lost_i(arb), .eng_err_i(err), .freeze_i(frz),
    .code_o(code_o), .flag_o(flag_o), .irq_o(irq_o));

  // behavioural reference
  logic [3:0] m_code [N];
  bit [N-1:0] m_flag, m_pend;
  bit m_busy;
  int m_idx;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) m_code[i] = C_INA;
      m_flag = '0; m_pend = '0; m_busy = 0; m_idx = 0;
    end else begin
      logic [3:0] nc [N];
      bit [N-1:0] np, setm;
      bit nb, start, term_this, infl;
      int ni, a, li;
      for (int i = 0; i < N; i++) nc[i] = m_code[i];
      np = m_pend; setm = '0; nb = m_busy; ni = m_idx;
      li = int'(load_idx); a = int'(cpu_addr);
      start = load && !m_busy && m_code[li] == C_ACT;
      if (m_busy) begin
        if (done) begin
          nc[m_idx] = C_INA; np[m_idx] = 0; setm[m_idx] = 1; nb = 0;
        end else if (m_pend[m_idx] && (arb || err || frz)) begin
          nc[m_idx] = C_ABT; np[m_idx] = 0; setm[m_idx] = 1; nb = 0;
        end else if (arb || err) nb = 0;
      end
      if (start) begin nb = 1; ni = li; end
      if (cpu_wr) begin
        term_this = m_busy && m_idx == a && (done || (m_pend[a] && (arb || err || frz)));
        infl = (m_busy && m_idx == a) || (start && li == a);
        if (!term_this) begin
          if (infl) begin
            if (abort_en && cpu_code == C_ABT && !(m_busy && m_idx == a && (arb || err)))
              np[a] = 1;
          end else nc[a] = cpu_code;
        end
      end
      for (int i = 0; i < N; i++) m_code[i] = nc[i];
      m_flag = setm | (m_flag & ~flag_clr);
      m_pend = np; m_busy = nb; m_idx = ni;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_ni) begin
      logic [4*N-1:0] ec;
      for (int i = 0; i < N; i++) ec[4*i +: 4] = m_code[i];
      checks++;
      if (code_o !== ec || flag_o !== m_flag || irq_o !== (|(m_flag & irq_en))) begin
        fails++;
        $display("FAIL %s model: code=%h flag=%h irq=%b exp code=%h flag=%h irq=%b",
                 cur_req, code_o, flag_o, irq_o, ec, m_flag, |(m_flag & irq_en));
      end
    end
  end

  function automatic logic [3:0] code_of(int i);
    return code_o[4*i +: 4];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [3:0] c);
    @(negedge clk); cpu_wr = 1; cpu_addr = IW'(a); cpu_code = c;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic ld(int i);
    @(negedge clk); load = 1; load_idx = IW'(i);
    @(negedge clk); load = 0;
  endtask

  task automatic ev(bit d, bit a, bit e, bit f);
    @(negedge clk); done = d; arb = a; err = e; frz = f;
    @(negedge clk); done = 0; arb = 0; err = 0; frz = 0;
  endtask

  task automatic clr(logic [N-1:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 codes", code_o, {N{C_INA}});
    chk("R1 flags", flag_o, '0);
    chk("R1 irq", irq_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 after release", code_o, {N{C_INA}});

    abort_en = 1; irq_en = ~(N'(1) << 5);
    cur_req = "R2";
    wr(3, C_ACT);  chk("R2 write active", code_of(3), C_ACT);
    wr(4, C_ACT);  wr(4, C_ABT);
    chk("R2 immediate abort", code_of(4), C_ABT);
    chk("R2 no flag", flag_o[4], 0);

    cur_req = "R4";
    ld(3); wr(3, C_ABT);
    chk("R4 blocked write", code_of(3), C_ACT);
    cur_req = "R5";
    ev(1, 0, 0, 0);
    chk("R5 done code", code_of(3), C_INA);
    chk("R5 done flag", flag_o[3], 1);
    chk("R10 irq on", irq_o, 1);

    cur_req = "R9";
    clr(N'(1) << 3);
    chk("R9 clear", flag_o[3], 0);
    chk("R10 irq off", irq_o, 0);

    cur_req = "R6";
    wr(6, C_ACT); ld(6); wr(6, C_ABT); ev(0, 1, 0, 0);
    chk("R6 arb abort code", code_of(6), C_ABT);
    chk("R6 arb abort flag", flag_o[6], 1);
    wr(7, C_ACT); ld(7); wr(7, C_ABT); ev(0, 0, 1, 0);
    chk("R6 err abort code", code_of(7), C_ABT);
    clr(N'(3) << 6);

    cur_req = "R7";
    wr(8, C_ACT); ld(8); ev(0, 0, 0, 1);
    chk("R7 freeze no pend", code_of(8), C_ACT);
    chk("R7 freeze no flag", flag_o[8], 0);
    wr(8, C_ABT); ev(0, 0, 0, 1);
    chk("R7 freeze abort code", code_of(8), C_ABT);
    chk("R7 freeze abort flag", flag_o[8], 1);
    clr(N'(1) << 8);

    cur_req = "R11";
    wr(9, C_ACT); ld(9); ev(0, 1, 0, 0);
    chk("R11 retry code", code_of(9), C_ACT);
    chk("R11 no flag", flag_o[9], 0);
    ld(9); ev(1, 0, 0, 0);
    chk("R11 reload done", code_of(9), C_INA);
    clr(N'(1) << 9);

    cur_req = "R8";
    abort_en = 0;
    wr(10, C_ACT); ld(10); wr(10, C_ABT);
    chk("R8 blocked", code_of(10), C_ACT);
    ev(0, 1, 0, 0);
    chk("R8 no abort code", code_of(10), C_ACT);
    chk("R8 no flag", flag_o[10], 0);
    ld(10); ev(1, 0, 0, 0);
    abort_en = 1;

    cur_req = "R9";
    clr(N'(1) << 10);
    wr(11, C_ACT); ld(11);
    @(negedge clk); done = 1; flag_clr = N'(1) << 11;
    @(negedge clk); done = 0; flag_clr = '0;
    chk("R9 set wins", flag_o[11], 1);
    clr(N'(1) << 11);

    cur_req = "R10";
    wr(5, C_ACT); ld(5); ev(1, 0, 0, 0);
    chk("R10 masked flag", flag_o[5], 1);
    chk("R10 masked irq", irq_o, 0);
    clr(N'(1) << 5);

    cur_req = "R3";
    wr(12, C_ACT); wr(13, C_ACT); ld(12); ld(13); ev(1, 0, 0, 0);
    chk("R3 first done", code_of(12), C_INA);
    chk("R3 second ignored", code_of(13), C_ACT);
    chk("R3 second no flag", flag_o[13], 0);
    ld(14); ev(1, 0, 0, 0);
    chk("R3 inactive load ignored", flag_o[14], 0);
    ld(13); ev(1, 0, 0, 0);
    clr('1);

    cur_req = "R4 random";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      abort_en = ($urandom % 8) != 0;
      cpu_wr   = ($urandom % 3) == 0;
      cpu_addr = IW'($urandom);
      case ($urandom % 3)
        0: cpu_code = C_ACT;
        1: cpu_code = C_ABT;
        default: cpu_code = C_INA;
      endcase
      load     = ($urandom % 3) == 0;
      load_idx = IW'($urandom);
      done     = ($urandom % 10) == 0;
      arb      = ($urandom % 12) == 0;
      err      = ($urandom % 15) == 0;
      frz      = ($urandom % 15) == 0;
      flag_clr = N'($urandom) & N'($urandom);
      irq_en   = N'($urandom);
    end
    @(negedge clk);
    cpu_wr = 0; load = 0; done = 0; arb = 0; err = 0; frz = 0; flag_clr = '0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule